// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block lets a host that runs on a clock read and write a 16-bit asynchronous static RAM. The host makes a request with a write flag, a word address, write data and one strobe per byte lane. It keeps the request high until the controller answers with a one-cycle acknowledge. For a read, the data is returned on the read-data port in the cycle the acknowledge is high.

The memory has no clock, so each of its timing minimums is given to the block in nanoseconds. The write pulse, the data setup, the read access and the output float time are each converted into a whole number of clock cycles at elaboration. The conversion rounds up and never gives less than one cycle. All memory control lines come straight from flops, so they do not glitch. The block owns the direction of the shared data bus. It drives the bus only during a write, plus one hold cycle after the write ends. After any read it waits for the memory outputs to float before it takes any new request.

A request whose lane strobes are both inactive is answered without any access to the memory. Between accesses the chip enable is high, which keeps the memory in standby.

Top module: `asram_ctrl`

## Requirements
- R1: After reset, and whenever no access is in progress, the chip, write, output and both byte enables are high (all are active low) and `ackPulse` is low.
- R2: `reqLanes[0]` selects data bits 7:0 and drives `memLbN`. `reqLanes[1]` selects bits 15:8 and drives `memUbN`. During an access, the enable of each selected lane is low and the enable of each unselected lane stays high.
- R3: A write holds `memCeN` and `memWeN` low together for exactly WR_CYC consecutive cycles, where WR_CYC = max(ceil(T_WP_NS/CLK_PERIOD_NS), ceil(T_DS_NS/CLK_PERIOD_NS), 1). `memOeN` stays high throughout the write.
- R4: The controller drives the write data onto `memDq` in every cycle that `memWeN` is low, and in the one cycle after `memWeN` rises.
- R5: A write changes only the selected byte lanes of the addressed word. The other lane keeps its earlier contents.
- R6: A read holds `memCeN` and `memOeN` low, with `memWeN` high, for exactly RD_CYC cycles, where RD_CYC = max(ceil(T_RC_NS/CLK_PERIOD_NS), ceil(T_OE_NS/CLK_PERIOD_NS), 1). The data of the selected lanes is captured in the last of these cycles. Unselected lanes read back as zero.
- R7: The controller never drives `memDq` until `memOeN` has been high for at least HZ_CYC = max(ceil(T_HZ_NS/CLK_PERIOD_NS), 1) cycles.
- R8: `ackPulse` is high for one cycle only. Counting the clock edge that accepts the request as edge 0, `ackPulse` goes high after edge WR_CYC for a write and after edge RD_CYC for a read. `rdData` holds the read result while `ackPulse` is high and keeps it until the next read.
- R9: A request with `reqLanes` = 00 is acknowledged after the accepting edge itself. No memory control line goes low, and the memory contents do not change.
- R10: `memAddr` changes only in a cycle that follows a cycle with `memCeN` high. Between two accesses, `memCeN` and `memWeN` are high for at least one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request; held until acknowledged, low in the acknowledge cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Word address |
| reqWdata | input | DATA_W | Write data |
| reqLanes | input | DATA_W/8 | Byte-lane strobes; bit 0 = bits 7:0, bit 1 = bits 15:8 |
| ackPulse | output | 1 | One-cycle completion strobe |
| rdData | output | DATA_W | Read result |
| memCeN | output | 1 | Chip enable, active low |
| memWeN | output | 1 | Write enable, active low |
| memOeN | output | 1 | Output enable, active low |
| memUbN | output | 1 | Upper-byte enable, active low |
| memLbN | output | 1 | Lower-byte enable, active low |
| memAddr | output | ADDR_W | Memory address |
| memDq | inout | DATA_W | Shared data bus |

## Verification
The bench builds the block with a 6-bit address and a 10 ns clock. The narrow address lets every word of the memory model be written and read back under all four lane masks. At 10 ns the timing values give four distinct counts: write pulse 5, data setup 3, read access 6 and float 2. This shows that the larger of two competing minimums is the one used. The short float count lets a write that follows a read directly reach the turnaround guard.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_FLOAT,
    ST_WRITE,
    ST_HOLD
  } ctrlState_t;

  // strobes from sequencer to datapath; pin-level fields come from flops
  typedef struct packed {
    logic load;
    logic capture;
    logic ceN;
    logic weN;
    logic oeN;
    logic laneOn;
    logic dqOe;
    logic ack;
  } strobes_t;

  function automatic int nsToCycles(input int ns, input int clkNs);
    int c;
    c = (ns + clkNs - 1) / clkNs;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int WR_CYC = 5,
  parameter int RD_CYC = 6,
  parameter int HZ_CYC = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [LANES-1:0] reqLanes,
  output strobes_t         strb
);

  localparam int MAX_CYC = maxOf(maxOf(WR_CYC, RD_CYC), HZ_CYC);
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  ctrlState_t       st;
  logic [CNT_W-1:0] cnt;
  logic             ceR, weR, oeR, laneR, dqR, ackR;

  wire accept  = (st == ST_IDLE) && reqValid;
  wire lastWr  = (cnt == CNT_W'(WR_CYC - 1));
  wire lastRd  = (cnt == CNT_W'(RD_CYC - 1));
  wire lastHz  = (cnt == CNT_W'(HZ_CYC - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st    <= ST_IDLE;
      cnt   <= '0;
      ceR   <= 1'b1;
      weR   <= 1'b1;
      oeR   <= 1'b1;
      laneR <= 1'b0;
      dqR   <= 1'b0;
      ackR  <= 1'b0;
    end else begin
      ackR <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          cnt <= '0;
          if (accept) begin
            if (reqLanes == '0) begin
              ackR <= 1'b1;
            end else if (reqWrite) begin
              st    <= ST_WRITE;
              ceR   <= 1'b0;
              weR   <= 1'b0;
              laneR <= 1'b1;
              dqR   <= 1'b1;
            end else begin
              st    <= ST_READ;
              ceR   <= 1'b0;
              oeR   <= 1'b0;
              laneR <= 1'b1;
            end
          end
        end
        ST_WRITE: begin
          if (lastWr) begin
            st    <= ST_HOLD;
            ceR   <= 1'b1;
            weR   <= 1'b1;
            laneR <= 1'b0;
            ackR  <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_HOLD: begin
          dqR <= 1'b0;
          st  <= ST_IDLE;
        end
        ST_READ: begin
          if (lastRd) begin
            st    <= ST_FLOAT;
            cnt   <= '0;
            ceR   <= 1'b1;
            oeR   <= 1'b1;
            laneR <= 1'b0;
            ackR  <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_FLOAT: begin
          if (lastHz) st <= ST_IDLE;
          else        cnt <= cnt + 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign strb = '{
    load:    accept && (reqLanes != '0),
    capture: (st == ST_READ) && lastRd,
    ceN:     ceR,
    weN:     weR,
    oeN:     oeR,
    laneOn:  laneR,
    dqOe:    dqR,
    ack:     ackR
  };

endmodule

// File: rtl/asram_dp.sv
module asram_dp
  import asram_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16,
  parameter int LANES  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [LANES-1:0]  reqLanes,
  input  logic [DATA_W-1:0] memDqIn,
  output logic [DATA_W-1:0] memDqOut,
  output logic              busDrive,
  output logic [ADDR_W-1:0] memAddr,
  output logic [LANES-1:0]  laneN,
  output logic              ceN,
  output logic              weN,
  output logic              oeN,
  output logic              ackPulse,
  output logic [DATA_W-1:0] rdData
);

  logic [ADDR_W-1:0] addrR;
  logic [DATA_W-1:0] wdR;
  logic [LANES-1:0]  lanesR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrR  <= '0;
      wdR    <= '0;
      lanesR <= '0;
    end else if (strb.load) begin
      addrR  <= reqAddr;
      wdR    <= reqWdata;
      lanesR <= reqLanes;
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             rdData[i*8 +: 8] <= '0;
      else if (strb.capture) rdData[i*8 +: 8] <= lanesR[i] ? memDqIn[i*8 +: 8] : 8'h00;
    end
    assign laneN[i] = !(strb.laneOn && lanesR[i]);
  end

  assign memAddr  = addrR;
  assign memDqOut = wdR;
  assign busDrive = strb.dqOe;
  assign ceN      = strb.ceN;
  assign weN      = strb.weN;
  assign oeN      = strb.oeN;
  assign ackPulse = strb.ack;

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W        = 18,
  parameter int DATA_W        = 16,
  parameter int CLK_PERIOD_NS = 10,
  parameter int T_WP_NS       = 45,
  parameter int T_DS_NS       = 25,
  parameter int T_RC_NS       = 55,
  parameter int T_OE_NS       = 25,
  parameter int T_HZ_NS       = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W/8-1:0] reqLanes,
  output logic              ackPulse,
  output logic [DATA_W-1:0] rdData,
  output logic              memCeN,
  output logic              memWeN,
  output logic              memOeN,
  output logic              memUbN,
  output logic              memLbN,
  output logic [ADDR_W-1:0] memAddr,
  inout  wire  [DATA_W-1:0] memDq
);

  localparam int LANES  = DATA_W / 8;
  localparam int WR_CYC = maxOf(nsToCycles(T_WP_NS, CLK_PERIOD_NS),
                                nsToCycles(T_DS_NS, CLK_PERIOD_NS));
  localparam int RD_CYC = maxOf(nsToCycles(T_RC_NS, CLK_PERIOD_NS),
                                nsToCycles(T_OE_NS, CLK_PERIOD_NS));
  localparam int HZ_CYC = nsToCycles(T_HZ_NS, CLK_PERIOD_NS);

  strobes_t          strb;
  logic [DATA_W-1:0] dqOut;
  logic              busDrive;
  logic [LANES-1:0]  laneN;

  asram_seq #(
    .LANES(LANES), .WR_CYC(WR_CYC), .RD_CYC(RD_CYC), .HZ_CYC(HZ_CYC)
  ) seq_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqLanes(reqLanes), .strb(strb)
  );

  asram_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .reqLanes(reqLanes), .memDqIn(memDq),
    .memDqOut(dqOut), .busDrive(busDrive), .memAddr(memAddr),
    .laneN(laneN), .ceN(memCeN), .weN(memWeN), .oeN(memOeN),
    .ackPulse(ackPulse), .rdData(rdData)
  );

  assign memLbN = laneN[0];
  assign memUbN = laneN[LANES-1];
  assign memDq  = busDrive ? dqOut : 'z;

endmodule

// File: rtl/asram_ctrl_checker.sv
module asram_ctrl_checker #(
  parameter int ADDR_W = 18,
  parameter int WR_CYC = 5,
  parameter int RD_CYC = 6,
  parameter int HZ_CYC = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              memCeN,
  input logic              memWeN,
  input logic              memOeN,
  input logic              memUbN,
  input logic              memLbN,
  input logic [ADDR_W-1:0] memAddr,
  input logic              busDrive,
  input logic              ackPulse
);

  int weRun;
  int oeRun;
  int oeHigh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      weRun  <= 0;
      oeRun  <= 0;
      oeHigh <= HZ_CYC;
    end else begin
      weRun  <= memWeN ? 0 : weRun + 1;
      oeRun  <= memOeN ? 0 : oeRun + 1;
      if (!memOeN)             oeHigh <= 0;
      else if (oeHigh < HZ_CYC) oeHigh <= oeHigh + 1;
    end
  end

  p_idle_standby_r1: assert property (@(posedge clk) disable iff (!rstN)
    memCeN |-> (memWeN && memOeN && memUbN && memLbN));

  p_lane_map_r2: assert property (@(posedge clk) disable iff (!rstN)
    !memCeN |-> !(memUbN && memLbN));

  p_write_no_oe_r3: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> (memOeN && !memCeN));

  p_we_pulse_len_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> (weRun == WR_CYC));

  p_drive_in_write_r4: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> busDrive);

  p_drive_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> busDrive);

  p_oe_len_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memOeN) |-> (oeRun == RD_CYC));

  p_no_contention_r7: assert property (@(posedge clk) disable iff (!rstN)
    busDrive |-> (memOeN && oeHigh >= HZ_CYC));

  p_ack_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    ackPulse |=> !ackPulse);

  p_addr_stable_r10: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(memAddr) |-> $past(memCeN));

endmodule

bind asram_ctrl asram_ctrl_checker #(
  .ADDR_W(ADDR_W), .WR_CYC(WR_CYC), .RD_CYC(RD_CYC), .HZ_CYC(HZ_CYC)
) chk_i (
  .clk(clk), .rstN(rstN), .memCeN(memCeN), .memWeN(memWeN),
  .memOeN(memOeN), .memUbN(memUbN), .memLbN(memLbN), .memAddr(memAddr),
  .busDrive(busDrive), .ackPulse(ackPulse)
);

// File: tb/asram_ctrl_tb.sv
`timescale 1ns/1ps
module asram_ctrl_tb_top;

  localparam int AW  = 6;
  localparam int DW  = 16;
  localparam int CLK = 10;
  localparam int TWP = 45, TDS = 25, TRC = 55, TOE = 25, THZ = 20;

  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK - 1) / CLK;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int EXP_WR = (cyc(TWP) > cyc(TDS)) ? cyc(TWP) : cyc(TDS);
  localparam int EXP_RD = (cyc(TRC) > cyc(TOE)) ? cyc(TRC) : cyc(TOE);
  localparam int EXP_HZ = cyc(THZ);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0;
  logic [1:0]    reqLanes = '0;
  logic          ackPulse;
  logic [DW-1:0] rdData;
  logic          memCeN, memWeN, memOeN, memUbN, memLbN;
  logic [AW-1:0] memAddr;
  wire  [DW-1:0] memDq;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  asram_ctrl #(
    .ADDR_W(AW), .DATA_W(DW), .CLK_PERIOD_NS(CLK), .T_WP_NS(TWP),
    .T_DS_NS(TDS), .T_RC_NS(TRC), .T_OE_NS(TOE), .T_HZ_NS(THZ)
  ) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqLanes(reqLanes),
    .ackPulse(ackPulse), .rdData(rdData), .memCeN(memCeN), .memWeN(memWeN),
    .memOeN(memOeN), .memUbN(memUbN), .memLbN(memLbN), .memAddr(memAddr),
    .memDq(memDq)
  );

  // memory model
  logic [DW-1:0] mem [0:(1<<AW)-1];
  wire rdOn = !memCeN && !memOeN && memWeN;
  assign memDq[7:0]  = (rdOn && !memLbN) ? mem[memAddr][7:0]  : 8'hzz;
  assign memDq[15:8] = (rdOn && !memUbN) ? mem[memAddr][15:8] : 8'hzz;

  always @(negedge clk) begin
    if (!memCeN && !memWeN) begin
      if (!memLbN) mem[memAddr][7:0]  <= memDq[7:0];
      if (!memUbN) mem[memAddr][15:8] <= memDq[15:8];
    end
  end

  // pin monitors (cumulative low-cycle counts)
  int ceLow = 0, weLow = 0, oeLow = 0, lbLow = 0, ubLow = 0;
  int oeHighRun = 100, minGap = 100, addrViol = 0;
  logic prevWeN = 1'b1, prevCeN = 1'b1;
  logic [AW-1:0] prevAddr = '0;

  always @(negedge clk) begin
    if (rstN) begin
      if (!memCeN) ceLow++;
      if (!memWeN) weLow++;
      if (!memOeN) oeLow++;
      if (!memLbN) lbLow++;
      if (!memUbN) ubLow++;
      if (!memWeN && prevWeN && oeHighRun < minGap) minGap = oeHighRun;
      if (!memOeN) oeHighRun = 0;
      else if (oeHighRun < 100) oeHighRun++;
      if (memAddr != prevAddr && !prevCeN) addrViol++;
      prevWeN  = memWeN;
      prevCeN  = memCeN;
      prevAddr = memAddr;
    end
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", rq, act, exp);
    end
  endtask

  logic [DW-1:0] shadow [0:(1<<AW)-1];

  function automatic logic [DW-1:0] laneMask(input logic [1:0] ln);
    return {{8{ln[1]}}, {8{ln[0]}}};
  endfunction

  // one access; checks latency, pin counts and data
  task automatic access(input bit wr, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input logic [1:0] ln,
                        input bit gapAfter);
    int lat;
    int c0, w0, o0, l0, u0;
    logic [DW-1:0] rd;
    lat = 0;
    rd  = '0;
    c0 = ceLow; w0 = weLow; o0 = oeLow; l0 = lbLow; u0 = ubLow;
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d; reqLanes = ln;
    while (1) begin
      @(negedge clk);
      lat++;
      if (ackPulse) begin
        rd = rdData;
        reqValid = 1'b0;
        break;
      end
      if (lat > 60) begin
        chk(1'b0, "R8 ack timeout", lat, 0);
        reqValid = 1'b0;
        break;
      end
    end
    @(negedge clk);
    chk(!ackPulse, "R8 ack one cycle", ackPulse, 0);
    if (ln == 2'b00) begin
      chk(lat == 1, "R9 skip latency", lat, 1);
      chk(ceLow == c0 && weLow == w0 && oeLow == o0 && lbLow == l0 && ubLow == u0,
          "R9 no control toggled", ceLow - c0 + weLow - w0 + oeLow - o0, 0);
    end else if (wr) begin
      chk(gapAfter == 1'b0 || lat == EXP_WR + 1, "R8 write latency", lat, EXP_WR + 1);
      chk(weLow - w0 == EXP_WR, "R3 we low cycles", weLow - w0, EXP_WR);
      chk(ceLow - c0 == EXP_WR, "R3 ce low cycles", ceLow - c0, EXP_WR);
      chk(oeLow == o0, "R3 oe stays high", oeLow - o0, 0);
      chk(lbLow - l0 == (ln[0] ? EXP_WR : 0), "R2 lower enable", lbLow - l0, ln[0] ? EXP_WR : 0);
      chk(ubLow - u0 == (ln[1] ? EXP_WR : 0), "R2 upper enable", ubLow - u0, ln[1] ? EXP_WR : 0);
      shadow[a] = (shadow[a] & ~laneMask(ln)) | (d & laneMask(ln));
    end else begin
      chk(lat == EXP_RD + 1, "R8 read latency", lat, EXP_RD + 1);
      chk(oeLow - o0 == EXP_RD, "R6 oe low cycles", oeLow - o0, EXP_RD);
      chk(weLow == w0, "R6 we stays high", weLow - w0, 0);
      chk(lbLow - l0 == (ln[0] ? EXP_RD : 0), "R2 lower enable", lbLow - l0, ln[0] ? EXP_RD : 0);
      chk(ubLow - u0 == (ln[1] ? EXP_RD : 0), "R2 upper enable", ubLow - u0, ln[1] ? EXP_RD : 0);
      chk(rd == (shadow[a] & laneMask(ln)), "R5 R6 read data", rd, shadow[a] & laneMask(ln));
      chk(rdData == rd, "R8 read data held", rdData, rd);
    end
    if (gapAfter) repeat (EXP_HZ + 1) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < (1 << AW); i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(memCeN && memWeN && memOeN && memUbN && memLbN, "R1 standby in reset",
        {memCeN, memWeN, memOeN, memUbN, memLbN}, 5'h1f);
    chk(!ackPulse, "R1 ack low in reset", ackPulse, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(memCeN && memWeN && memOeN && memUbN && memLbN, "R1 standby idle",
        {memCeN, memWeN, memOeN, memUbN, memLbN}, 5'h1f);

    for (int a = 0; a < (1 << AW); a++) begin
      logic [DW-1:0] w;
      w = 16'(a * 16'h9E37 + 16'h1234);
      access(1'b1, AW'(a), w, 2'b11, 1'b1);
    end
    for (int a = 0; a < (1 << AW); a++) begin
      access(1'b0, AW'(a), '0, 2'b11, 1'b1);
      access(1'b0, AW'(a), '0, 2'b01, 1'b1);
      access(1'b0, AW'(a), '0, 2'b10, 1'b1);
      access(1'b0, AW'(a), '0, 2'b00, 1'b1);
      access(1'b1, AW'(a), 16'(a * 16'h0101 ^ 16'hC35A), 2'b01, 1'b1); // R5 lower only
      access(1'b0, AW'(a), '0, 2'b11, 1'b1);
      access(1'b1, AW'(a), 16'(a * 16'h0707 ^ 16'h5AA5), 2'b10, 1'b1); // R5 upper only
      access(1'b0, AW'(a), '0, 2'b11, 1'b1);
      access(1'b1, AW'(a), 16'hFFFF, 2'b00, 1'b1);                      // R9 skip write
      access(1'b0, AW'(a), '0, 2'b11, 1'b1);
    end

    // R7 turnaround: write requested right after a read
    minGap = 100;
    for (int a = 0; a < 8; a++) begin
      access(1'b0, AW'(a), '0, 2'b11, 1'b0);
      access(1'b1, AW'(a), 16'(16'hA000 + a), 2'b11, 1'b0);
    end
    repeat (EXP_HZ + 1) @(negedge clk);
    chk(minGap >= EXP_HZ, "R7 float gap before write", minGap, EXP_HZ);
    for (int a = 0; a < 8; a++) access(1'b0, AW'(a), '0, 2'b11, 1'b1);

    chk(addrViol == 0, "R10 address moved during access", addrViol, 0);
    chk(memCeN && memWeN && memOeN && memUbN && memLbN, "R1 standby at end",
        {memCeN, memWeN, memOeN, memUbN, memLbN}, 5'h1f);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule